// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each bus access into at most one active-low select line. It holds eight programmable windows. Each window has a base word and a mask word. Together they give the window's start address, its size as a power of two, the function codes it answers to, a write-protect flag and an enable flag. The decode is purely combinational from the address, the function code, the read/write line and the address strobe. Only the configuration words are registered.

Out of reset, no window is enabled, and select 0 runs in a boot mode. In this mode it answers every address and every function code, reads and writes alike, so a boot memory can be reached before anything is programmed. All other selects are held off during boot mode. Setting the enable flag of window 0 ends boot mode, and from then on window 0 decodes like the rest. When enabled windows overlap, the lowest-numbered one wins. The block also reports which window won, so that downstream bus-termination logic can look up that window's timing.

The block carries no data stream: every pin is a plain control or status line, and the register port has no handshake. A write is taken on any clock edge where the write enable is high.

Top module: `csel_decoder`

## Requirements
- R1: After reset, every window is disabled and the block is in boot mode.
- R2: In boot mode, with the strobe active, `cs_n[0]` is low for any address, any function code, and for reads as well as writes.
- R3: In boot mode, `cs_n[7:1]` stay high, even for windows already enabled.
- R4: A register write on a clock edge with `reg_we` high updates one word. `reg_addr[3:1]` selects the window and `reg_addr[0]` selects the word (0 = base, 1 = mask). Base word fields: `[31:8]` window start address, `[7:5]` function code, `[1]` write protect, `[0]` enable. Mask word fields: `[5:0]` log2 of the window size in bytes, `[10:8]` function-code don't-care bits. An enabled window hits when every address bit at or above log2(size) equals the same bit of its start address.
- R5: A size code below 8 is treated as 8 (256 bytes). A size code of 32 or more makes the window cover all 4 GB.
- R6: A window hits only when every function-code bit equals its configured bit, except bits whose don't-care bit is 1.
- R7: A window with write protect set does not hit on a write (`rd_wr_n` = 0), but does hit on a read.
- R8: At most one select is low in any cycle. When several enabled windows hit, only the lowest-numbered one is selected.
- R9: While `as_n` is high, all selects are high and `hit_any` is 0.
- R10: `hit_any` is 1 exactly when some select is low, and `hit_idx` then gives that select's number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Configuration write enable |
| reg_addr | input | 4 | Window number and word select |
| reg_wdata | input | 32 | Configuration write data |
| addr | input | 32 | Bus address |
| fc | input | 3 | Function code of the access |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Active-low address strobe |
| cs_n | output | 8 | Active-low selects, one per window |
| hit_any | output | 1 | Some select is active |
| hit_idx | output | 3 | Number of the active select |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is window overlap with priority. A 64 KB window 0 is placed inside a 1 MB window 3, and an address in the shared range must raise only select 0. An address in the outer range only must raise select 3. The second pair is boot mode with an enabled window. Window 3 is fully programmed while window 0 is still disabled, and an address inside window 3 must then give select 0 alone. Function-code masking and write protect are tested on addresses that match by address, so that only the qualifier decides the outcome.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CSEL_AW   = 32;
  localparam int CSEL_FCW  = 3;
  localparam int CSEL_SZW  = 6;
  localparam int CSEL_MIN_LOG2 = 8;

  // field positions inside the configuration words
  localparam int BASE_FC_LSB = 5;
  localparam int BASE_WP_BIT = 1;
  localparam int BASE_EN_BIT = 0;
  localparam int MASK_DC_LSB = 8;

  typedef struct packed {
    logic [CSEL_AW-1:0]  start;
    logic [CSEL_FCW-1:0] fc;
    logic [CSEL_FCW-1:0] fc_dc;
    logic [CSEL_SZW-1:0] size_log2;
    logic                wp;
    logic                en;
  } win_cfg_t;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int RA_W = $clog2(NUM_WIN) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RA_W-1:0]    waddr,
  input  logic [CSEL_AW-1:0] wdata,
  output win_cfg_t           cfg [NUM_WIN]
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[CSEL_AW-1:MASK_DC_LSB+CSEL_FCW], wdata[MASK_DC_LSB-1:CSEL_SZW]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = we && (waddr[RA_W-1:1] == w[RA_W-2:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[w] <= '0;
      end else if (sel) begin
        if (!waddr[0]) begin
          cfg[w].start <= {wdata[CSEL_AW-1:CSEL_MIN_LOG2], {CSEL_MIN_LOG2{1'b0}}};
          cfg[w].fc    <= wdata[BASE_FC_LSB +: CSEL_FCW];
          cfg[w].wp    <= wdata[BASE_WP_BIT];
          cfg[w].en    <= wdata[BASE_EN_BIT];
        end else begin
          cfg[w].size_log2 <= wdata[CSEL_SZW-1:0];
          cfg[w].fc_dc     <= wdata[MASK_DC_LSB +: CSEL_FCW];
        end
      end
    end
  end
endmodule

// File: rtl/csel_win_match.sv
module csel_win_match
  import csel_pkg::*;
(
  input  win_cfg_t            cfg,
  input  logic [CSEL_AW-1:0]  addr,
  input  logic [CSEL_FCW-1:0] fc,
  input  logic                is_write,
  input  logic                force_hit,
  input  logic                blocked,
  output logic                hit
);
  logic [CSEL_SZW-1:0] n_eff;
  logic                addr_ok;
  logic                fc_ok;
  logic                unused_low;

  assign unused_low = ^{addr[CSEL_MIN_LOG2-1:0], cfg.start[CSEL_MIN_LOG2-1:0]};

  always_comb begin
    if (cfg.size_log2 < CSEL_SZW'(CSEL_MIN_LOG2))
      n_eff = CSEL_SZW'(CSEL_MIN_LOG2);
    else if (cfg.size_log2 > CSEL_SZW'(CSEL_AW))
      n_eff = CSEL_SZW'(CSEL_AW);
    else
      n_eff = cfg.size_log2;
  end

  always_comb begin
    addr_ok = 1'b1;
    for (int b = CSEL_MIN_LOG2; b < CSEL_AW; b++) begin
      if (CSEL_SZW'(b) >= n_eff && addr[b] != cfg.start[b]) addr_ok = 1'b0;
    end
  end

  assign fc_ok = &((fc ~^ cfg.fc) | cfg.fc_dc);
  assign hit   = force_hit ||
                 (!blocked && cfg.en && addr_ok && fc_ok && !(cfg.wp && is_write));
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int RA_W  = $clog2(NUM_WIN) + 1,
  localparam int IDX_W = $clog2(NUM_WIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [CSEL_AW-1:0]  reg_wdata,
  input  logic [CSEL_AW-1:0]  addr,
  input  logic [CSEL_FCW-1:0] fc,
  input  logic                rd_wr_n,
  input  logic                as_n,
  output logic [NUM_WIN-1:0]  cs_n,
  output logic                hit_any,
  output logic [IDX_W-1:0]    hit_idx
);
  win_cfg_t            cfg [NUM_WIN];
  logic [NUM_WIN-1:0]  win_hit;
  logic [NUM_WIN-1:0]  grant;
  logic [IDX_W-1:0]    pidx;
  logic                pany;
  logic                global_mode;
  logic                strobe;

  csel_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr),
    .wdata(reg_wdata), .cfg(cfg)
  );

  assign global_mode = !cfg[0].en;
  assign strobe      = !as_n;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    csel_win_match u_match (
      .cfg(cfg[w]), .addr(addr), .fc(fc), .is_write(!rd_wr_n),
      .force_hit((w == 0) && global_mode),
      .blocked((w != 0) && global_mode),
      .hit(win_hit[w])
    );
  end

  csel_prio #(.N(NUM_WIN)) u_prio (
    .req(win_hit), .grant(grant), .idx(pidx), .any(pany)
  );

  assign cs_n    = ~(grant & {NUM_WIN{strobe}});
  assign hit_any = pany && strobe;
  assign hit_idx = strobe ? pidx : '0;
endmodule

module csel_decoder_chk #(
  parameter int NUM_WIN = 8,
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               as_n,
  input logic [NUM_WIN-1:0] cs_n,
  input logic               hit_any,
  input logic [IDX_W-1:0]   hit_idx,
  input logic               glob
);
  // R9
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (&cs_n && !hit_any));
  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R3
  boot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glob |-> &cs_n[NUM_WIN-1:1]);
  // R2
  boot_sel0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glob && !as_n) |-> !cs_n[0]);
  // R10
  idx_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> !cs_n[hit_idx]);
  // R10
  none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> &cs_n);
endmodule

bind csel_decoder csel_decoder_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n),
  .hit_any(hit_any), .hit_idx(hit_idx), .glob(global_mode)
);

// File: tb/csel_decoder_test.sv
module csel_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        rd_wr_n = 1'b1;
  logic        as_n = 1'b1;
  logic [7:0]  cs_n;
  logic        hit_any;
  logic [2:0]  hit_idx;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  csel_decoder uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .addr(addr), .fc(fc), .rd_wr_n(rd_wr_n),
    .as_n(as_n), .cs_n(cs_n), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  task automatic wr(input int win, input bit mask_word, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {3'(win), mask_word}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] f, input bit rd, input bit strobe);
    @(negedge clk);
    addr = a; fc = f; rd_wr_n = rd; as_n = !strobe;
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] exp_cs, input bit exp_any, input logic [2:0] exp_idx);
    compared++;
    if (cs_n !== exp_cs || hit_any !== exp_any || (exp_any && hit_idx !== exp_idx)) begin
      mismatched++;
      $display("FAIL %s: cs_n=%h any=%0b idx=%0d expected cs_n=%h any=%0b idx=%0d",
               req, cs_n, hit_any, hit_idx, exp_cs, exp_any, exp_idx);
    end
  endtask

  task automatic t_reset_boot();
    access(32'h1234_5678, 3'd2, 1'b1, 1'b0);
    chk("R9 idle after reset", 8'hFF, 1'b0, 3'd0);
    access(32'h1234_5678, 3'd2, 1'b1, 1'b1);
    chk("R1 boot select read", 8'hFE, 1'b1, 3'd0);
    access(32'hFFFF_FFFC, 3'd7, 1'b0, 1'b1);
    chk("R2 boot select write", 8'hFE, 1'b1, 3'd0);
  endtask

  task automatic t_boot_blocks();
    wr(3, 1'b0, 32'h1000_00A1);
    wr(3, 1'b1, 32'h0000_0014);
    access(32'h1008_0000, 3'd5, 1'b1, 1'b1);
    chk("R3 window 3 held off in boot", 8'hFE, 1'b1, 3'd0);
  endtask

  task automatic t_program();
    wr(5, 1'b0, 32'h2000_0003);
    wr(5, 1'b1, 32'h0000_0708);
    wr(6, 1'b0, 32'h3000_0101);
    wr(6, 1'b1, 32'h0000_0704);
    wr(7, 1'b0, 32'h0000_0061);
    wr(7, 1'b1, 32'h0000_0020);
    wr(0, 1'b1, 32'h0000_0710);
    wr(0, 1'b0, 32'h1000_0001);
  endtask

  task automatic t_decode();
    access(32'h1000_1234, 3'd5, 1'b1, 1'b1);
    chk("R8 overlap lowest wins", 8'hFE, 1'b1, 3'd0);
    access(32'h1008_0000, 3'd5, 1'b1, 1'b1);
    chk("R4 window 3 hit", 8'hF7, 1'b1, 3'd3);
    access(32'h1010_0000, 3'd5, 1'b1, 1'b1);
    chk("R4 past window end", 8'hFF, 1'b0, 3'd0);
    access(32'h1008_0000, 3'd4, 1'b1, 1'b1);
    chk("R6 fc mismatch", 8'hFF, 1'b0, 3'd0);
  endtask

  task automatic t_sizes_wp();
    access(32'h2000_00FF, 3'd1, 1'b1, 1'b1);
    chk("R7 wp window read", 8'hDF, 1'b1, 3'd5);
    access(32'h2000_0010, 3'd1, 1'b0, 1'b1);
    chk("R7 wp window write", 8'hFF, 1'b0, 3'd0);
    access(32'h2000_0100, 3'd1, 1'b1, 1'b1);
    chk("R5 256 byte edge", 8'hFF, 1'b0, 3'd0);
    access(32'h3000_01FF, 3'd0, 1'b0, 1'b1);
    chk("R5 small code clamped in", 8'hBF, 1'b1, 3'd6);
    access(32'h3000_0200, 3'd0, 1'b0, 1'b1);
    chk("R5 small code clamped out", 8'hFF, 1'b0, 3'd0);
    access(32'hDEAD_BEEF, 3'd3, 1'b0, 1'b1);
    chk("R5 full space window", 8'h7F, 1'b1, 3'd7);
  endtask

  task automatic t_fc_mask_strobe();
    wr(3, 1'b1, 32'h0000_0114);
    access(32'h1008_0000, 3'd4, 1'b1, 1'b1);
    chk("R6 fc bit0 dont care", 8'hF7, 1'b1, 3'd3);
    access(32'h1008_0000, 3'd4, 1'b1, 1'b0);
    chk("R9 strobe idle", 8'hFF, 1'b0, 3'd0);
    access(32'h0000_0000, 3'd3, 1'b1, 1'b1);
    chk("R10 index reported", 8'h7F, 1'b1, 3'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_boot();
    t_boot_blocks();
    t_program();
    t_decode();
    t_sizes_wp();
    t_fc_mask_strobe();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule